// File: doc/BRIEF.md
# Two-Wire Debug Port Register Readout

This block is the target-side part of a two-wire serial programming port. The host supplies a clock and shares one bidirectional data line with the target. The block samples both wires in the fast system clock domain through synchronizers. It detects rising and falling edges of the host clock and collects a 4-bit command, least significant bit first, on rising edges.

When the command is the register-read code, the block raises a CPU-idle flag for eight host clocks. It then captures a 16-bit visibility word and turns the data line around to output. The word leaves least significant bit first, with one new bit on each falling edge of the host clock. After the final bit the block keeps driving until the next rising edge, then releases the line and waits for the next command. Any other command is dropped without effect.

Top module: `dbgp_regread_port`

## Requirements
- R1: While and after a synchronous reset, `host_dat_oe` and `cpu_idle` are 0 and the block waits for the first bit of a new 4-bit code.
- R2: A code is four bits sampled on rising host-clock edges, first bit into bit 0. The register-read code is 4'b0001: a first bit of 1 followed by three 0 bits. `host_dat_oe` stays 0 while a code is received.
- R3: After the register-read code, `cpu_idle` is 1 for exactly the next 8 rising host-clock edges and falls on the 8th. `host_dat_oe` stays 0 during this gap.
- R4: The 16-bit word is driven least significant bit first. Bit 0 appears on the falling edge that follows the 8th idle rising edge, and each later falling edge presents the next bit. The host therefore reads bit i just before rising edge i+1 of the shift phase.
- R5: `reg_value` is captured on the 8th idle rising edge. Later changes do not alter the word being sent.
- R6: After bit 15, `host_dat_oe` stays 1 until the next rising host-clock edge and then drops to 0. That rising edge is not taken as a code bit, so a new code may start on the following rising edge.
- R7: A code other than 4'b0001 causes no output drive and no idle flag. The next four bits are treated as a fresh code.
- R8: While `host_dat_oe` is 1, `host_dat_out` changes only in response to a falling host-clock edge.
- R9: A reset in the middle of a readout drops the output enable and the idle flag at once, and the next code is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk_in | input | 1 | Host serial clock, asynchronous |
| host_dat_in | input | 1 | Data line as seen at the pin |
| reg_value | input | 16 | Visibility word to be read out |
| host_dat_out | output | 1 | Data driven toward the host |
| host_dat_oe | output | 1 | Output enable for the data line |
| cpu_idle | output | 1 | CPU hold-idle indication |

## Verification
The bench counts the idle gap edge by edge. A design that is one cycle off in either direction moves every bit of the word by one position, which the readback catches. Words with a single set bit at either end, such as 0x8001, expose bit-order and first-bit timing errors. A word changed after the first bit shows whether the design captured a snapshot or shifts the live input. Back-to-back reads right after the release edge expose a design that takes the release edge as a code bit or releases the line a clock early. Invalid codes, and a reset mid-word, confirm that the line is never driven when it should be an input.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_CODE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } rd_state_t;
endpackage

// File: rtl/dbgp_edge_sync.sv
module dbgp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hclk_async,
  input  logic hdat_async,
  output logic hdat_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dat_chain;
  logic              clk_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[0] <= 1'b0;
            dat_chain[0] <= 1'b0;
          end else begin
            clk_chain[0] <= hclk_async;
            dat_chain[0] <= hdat_async;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            clk_chain[g] <= 1'b0;
            dat_chain[g] <= 1'b0;
          end else begin
            clk_chain[g] <= clk_chain[g-1];
            dat_chain[g] <= dat_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= clk_chain[STAGES-1];
  end

  assign hdat_s = dat_chain[STAGES-1];
  assign rise   = clk_chain[STAGES-1] & ~clk_prev;
  assign fall   = ~clk_chain[STAGES-1] & clk_prev;
endmodule

// File: rtl/dbgp_code_rx.sv
module dbgp_code_rx #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rise,
  input  logic              din,
  output logic              done,
  output logic [CODE_W-1:0] code
);
  localparam int CNT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CODE_W-1:0] sreg;
  logic [CODE_W-1:0] sreg_nx;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    if (CODE_W > 1) sreg_nx = {din, sreg[CODE_W-1:1]};
    else            sreg_nx = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
      done <= 1'b0;
      code <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (rise) begin
        sreg <= sreg_nx;
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
          code <= sreg_nx;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  code_shift_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sreg) |-> ($past(rise) && $past(en)));
endmodule

// File: rtl/dbgp_readout.sv
module dbgp_readout
  import dbgp_pkg::*;
#(
  parameter int              CODE_W    = 4,
  parameter logic [CODE_W-1:0] READ_CODE = 4'b0001,
  parameter int              IDLE_CYC  = 8,
  parameter int              WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              code_done,
  input  logic [CODE_W-1:0] code,
  input  logic [WORD_W-1:0] word_in,
  output logic              listening,
  output logic              dout,
  output logic              oe,
  output logic              idle
);
  localparam int IC_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IC_W-1:0] IDLE_LAST = IC_W'(IDLE_CYC - 1);
  localparam logic [BC_W-1:0] BIT_LAST  = BC_W'(WORD_W - 1);

  rd_state_t         state;
  logic [IC_W-1:0]   idle_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CODE;
      idle_cnt <= '0;
      bit_cnt  <= '0;
      sreg     <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
      idle     <= 1'b0;
    end else begin
      unique case (state)
        ST_CODE: begin
          if (code_done && code == READ_CODE) begin
            state    <= ST_HOLD;
            idle_cnt <= '0;
            idle     <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (rise) begin
            if (idle_cnt == IDLE_LAST) begin
              state   <= ST_SHIFT;
              idle    <= 1'b0;
              sreg    <= word_in;
              bit_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (fall) begin
            oe   <= 1'b1;
            dout <= sreg[0];
            sreg <= sreg >> 1;
            if (bit_cnt == BIT_LAST) state <= ST_TAIL;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (rise) begin
            oe    <= 1'b0;
            state <= ST_CODE;
          end
        end
        default: state <= ST_CODE;
      endcase
    end
  end

  assign listening = (state == ST_CODE);

  // R3
  idle_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(idle && oe));

  // R3
  idle_end_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> ($past(rise) || $past(rst)));

  // R4
  oe_start_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(fall));

  // R6
  oe_release_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> ($past(rise) || $past(rst)));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && $past(oe) && !$past(fall)) |-> $stable(dout));
endmodule

// File: rtl/dbgp_regread_port.sv
module dbgp_regread_port #(
  parameter int                SYNC_STAGES = 2,
  parameter int                CODE_W      = 4,
  parameter logic [CODE_W-1:0] READ_CODE   = 4'b0001,
  parameter int                IDLE_CYC    = 8,
  parameter int                WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_clk_in,
  input  logic              host_dat_in,
  input  logic [WORD_W-1:0] reg_value,
  output logic              host_dat_out,
  output logic              host_dat_oe,
  output logic              cpu_idle
);
  logic              dat_s;
  logic              hrise;
  logic              hfall;
  logic              rx_en;
  logic              rx_done;
  logic [CODE_W-1:0] rx_code;

  dbgp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .hclk_async (host_clk_in),
    .hdat_async (host_dat_in),
    .hdat_s     (dat_s),
    .rise       (hrise),
    .fall       (hfall)
  );

  dbgp_code_rx #(.CODE_W(CODE_W)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .en   (rx_en),
    .rise (hrise),
    .din  (dat_s),
    .done (rx_done),
    .code (rx_code)
  );

  dbgp_readout #(
    .CODE_W    (CODE_W),
    .READ_CODE (READ_CODE),
    .IDLE_CYC  (IDLE_CYC),
    .WORD_W    (WORD_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .rise      (hrise),
    .fall      (hfall),
    .code_done (rx_done),
    .code      (rx_code),
    .word_in   (reg_value),
    .listening (rx_en),
    .dout      (host_dat_out),
    .oe        (host_dat_oe),
    .idle      (cpu_idle)
  );
endmodule

// File: tb/tb_dbgp_regread_port.sv
`timescale 1ns/1ps
module tb_dbgp_regread_port;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hclk = 1'b0;
  logic        hdat = 1'b0;
  logic [15:0] regv = 16'h0000;
  logic        dout, oe, idle;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dbgp_regread_port dut (
    .clk (clk), .rst (rst), .host_clk_in (hclk), .host_dat_in (hdat),
    .reg_value (regv), .host_dat_out (dout), .host_dat_oe (oe), .cpu_idle (idle)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wsys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one host clock: drive data, low phase, sample, rise, high phase, fall
  task automatic pulse(input logic b, output logic s_d, output logic s_oe, output logic s_id);
    hdat = b;
    wsys(HALF);
    s_d = dout; s_oe = oe; s_id = idle;
    hclk = 1'b1;
    wsys(HALF);
    hclk = 1'b0;
  endtask

  task automatic send_code(input logic [3:0] c, input string tag);
    logic d, o, i;
    for (int k = 0; k < 4; k++) begin
      pulse(c[k], d, o, i);
      chk({tag, " R2 oe low during code"}, o, 0);
    end
  endtask

  // full read; optional change of reg_value after first bit (R5)
  task automatic do_read(input logic [15:0] w, input bit alter, input string tag);
    logic d, o, i;
    logic [15:0] got;
    regv = w;
    send_code(4'b0001, tag);
    for (int k = 0; k < 8; k++) begin
      pulse(1'b0, d, o, i);
      chk({tag, " R3 idle high in gap"}, i, 1);
      chk({tag, " R3 oe low in gap"}, o, 0);
    end
    for (int k = 0; k < 16; k++) begin
      pulse(1'b0, d, o, i);
      if (alter && k == 1) regv = ~w;
      got[k] = d;
      chk({tag, " R4 oe high in shift"}, o, 1);
      chk({tag, " R3 idle low in shift"}, i, 0);
    end
    chk({tag, " R4 word LSb first"}, got, w);
    wsys(HALF);
    chk({tag, " R6 released after next rise"}, oe, 0);
  endtask

  task automatic t_reset;
    chk("R1 oe after reset", oe, 0);
    chk("R1 idle after reset", idle, 0);
  endtask

  task automatic t_reads;
    do_read(16'hA5C3, 0, "readA");
    do_read(16'h8001, 0, "read8001");
    do_read(16'h0000, 0, "read0000");
    do_read(16'hFFFF, 0, "readFFFF");
  endtask

  task automatic t_capture;
    do_read(16'h3C96, 1, "R5 capture");
  endtask

  task automatic t_bad_codes;
    logic d, o, i;
    logic [3:0] bad [3] = '{4'b1000, 4'b0011, 4'b0000};
    foreach (bad[j]) begin
      send_code(bad[j], "R7 bad");
      for (int k = 0; k < 3; k++) begin
        hdat = 1'b0;
        wsys(4);
        chk("R7 no idle after bad code", idle, 0);
        chk("R7 no drive after bad code", oe, 0);
      end
    end
    do_read(16'h1234, 0, "R7 read after bad");
  endtask

  task automatic t_back_to_back;
    do_read(16'h0F0F, 0, "R6 b2b first");
    do_read(16'hF00E, 0, "R6 b2b second");
  endtask

  task automatic t_reset_mid;
    logic d, o, i;
    regv = 16'hBEEF;
    send_code(4'b0001, "R9 pre");
    for (int k = 0; k < 12; k++) pulse(1'b0, d, o, i);
    chk("R9 driving before reset", oe, 1);
    rst = 1'b1;
    wsys(2);
    chk("R9 oe cleared", oe, 0);
    chk("R9 idle cleared", idle, 0);
    rst = 1'b0;
    wsys(4);
    do_read(16'h7E81, 0, "R9 read after reset");
  endtask

  initial begin
    wsys(5);
    t_reset;
    rst = 1'b0;
    wsys(5);
    t_reset;
    t_reads;
    t_capture;
    t_bad_codes;
    t_back_to_back;
    t_reset_mid;
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wsys(150000);
    if (!done_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule